// File: doc/BRIEF.md
# Telephony codec serial frame port

This block is the device end of a synchronous serial link. One wire pair carries voice samples and control-register traffic between a host signal processor and a codec. The block runs from a single master clock and derives the serial bit clock from it by a programmable even division. It drives the bit clock and the frame marker toward the host. Each frame is 256 bit-clock periods long. Every frame opens with a 16-bit primary slot: the receive sample goes out and the transmit sample comes in.

A second 16-bit slot, 128 bit periods after the start of the primary slot, is inserted only when the host asks for it. The request comes from one of two places, and a control bit selects which. At reset the request is the least significant bit of the transmit word, so only 15 sample bits pass to the converter. With the wide bit set, all 16 bits are sample data and the request is taken from a dedicated pin instead. The second slot reads or writes one entry of an internal 8-bit register file. That file also holds the wide bit and the clock divisor. Toward the converter side the block offers a parallel receive-sample input and a transmit-sample output with a one-cycle valid strobe.

Top module: `tsf_port`

## Requirements
- R1: A frame is exactly 256 SCLK periods. FSYNC is high for the whole SCLK period just before the first primary bit, and low during that first bit.
- R2: SCLK has a period of 2*H MCLK cycles, where H is the value of register 2. H resets to 2, and a value of 0 acts as 1.
- R3: In the primary slot, SDO carries the 16-bit rx_sample captured at the frame start, MSB first. SDO changes only in the MCLK cycle in which SCLK rises.
- R4: With register 1 bit 0 clear (the reset state), tx_sample is the 15 upper SDI bits of the primary slot followed by a 0. Bit 0 of the word requests the second slot, and the fc pin has no effect.
- R5: With register 1 bit 0 set, tx_sample holds all 16 SDI bits. The second slot is requested when fc is high at the SCLK falling edge that ends the last primary bit.
- R6: The second slot is present only in a frame that requested it. FSYNC is then high in the SCLK period just before it (period 127), and low there otherwise. SDO is 0 outside active data bits.
- R7: The second-slot word is shifted MSB first: bit 15 is 0, bit 14 selects read (1) or write (0), bits 13:9 are the address, bits 8:1 are the data, and bit 0 is 0. A write stores bits 8:1 at the address.
- R8: On a read, SDO returns the addressed register in bits 8:1 of the slot, with all other slot bits 0.
- R9: Addresses 24 to 31 are unused. Writes to them are ignored, and reads from them return 0.
- R10: After reset, SDO, FSYNC, SCLK and tx_valid are 0, and every register is 0 except register 2, which holds 2.
- R11: tx_valid pulses for one MCLK cycle per frame, in the cycle SCLK falls at the end of the last primary bit, together with the new tx_sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mclk | input | 1 | Master clock; all logic is synchronous to it |
| rst_n | input | 1 | Synchronous active-low reset |
| sdi | input | 1 | Serial data from the host, sampled on SCLK falling edges |
| fc | input | 1 | Hardware request for a second slot (wide mode only) |
| rx_sample | input | 16 | Receive sample from the converter, sent in the primary slot |
| sclk | output | 1 | Serial bit clock |
| fsync | output | 1 | Frame/slot marker, one SCLK period ahead of a slot |
| sdo | output | 1 | Serial data to the host, changed on SCLK rising edges |
| tx_sample | output | 16 | Transmit sample toward the converter |
| tx_valid | output | 1 | One-cycle strobe marking a new tx_sample |

## Verification
Each SDO bit is due in the MCLK cycle where SCLK rises, and holds until the next rise. The bench therefore reads it one nanosecond after the following SCLK fall, and drives SDI one nanosecond after each rise. tx_sample and tx_valid are due at the SCLK fall that ends primary bit 15. The scoreboard monitor compares them on the falling MCLK edge inside that single-cycle pulse. A register write takes effect at the fall that ends slot bit 0, so its effect is checked from a later frame or by a read in a following frame. FSYNC is checked one nanosecond after the rises into periods 0, 127 and 255, and the divisor is checked by counting MCLK edges between two SCLK rises.

// File: rtl/tsf_pkg.sv
// Shared constants for the serial frame port: frame geometry, slot
// positions (as SCLK period indices within a frame) and register addresses.
package tsf_pkg;
    localparam int SAMPLE_W = 16;
    localparam int CNT_W    = 8;
    localparam int ADDR_W   = 5;
    localparam int DATA_W   = 8;
    localparam int NUM_ADDR = 1 << ADDR_W;

    localparam logic [CNT_W-1:0] SLOT_LAST     = 8'd15;
    localparam logic [CNT_W-1:0] SEC_SYNC      = 8'd127;
    localparam logic [CNT_W-1:0] SEC_FIRST     = 8'd128;
    localparam logic [CNT_W-1:0] SEC_ADDR_DONE = 8'd134;
    localparam logic [CNT_W-1:0] SEC_DATA_HI   = 8'd135;
    localparam logic [CNT_W-1:0] SEC_DATA_LO   = 8'd142;
    localparam logic [CNT_W-1:0] SEC_LAST      = 8'd143;
    localparam logic [CNT_W-1:0] FRAME_LAST    = 8'd255;

    localparam logic [ADDR_W-1:0] REG_CTRL = 5'd1;
    localparam logic [ADDR_W-1:0] REG_DIV  = 5'd2;
endpackage

// File: rtl/tsf_clkdiv.sv
// Bit clock generator. Toggles sclk every 'half' MCLK cycles (0 acts as 1)
// and flags the MCLK cycle in which sclk rises or falls, so that all other
// logic stays in the MCLK domain. Assumes half may change at any time.
module tsf_clkdiv #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] half,
    output logic          sclk,
    output logic          rise_en,
    output logic          fall_en
);
    logic [CW-1:0] hcnt;
    logic [CW-1:0] lim;
    logic          term;

    // Terminal count of the current half period.
    assign lim     = (half == '0) ? '0 : half - 1'b1;
    assign term    = (hcnt >= lim);
    assign rise_en = term & ~sclk;
    assign fall_en = term & sclk;

    // Half-period counter and clock toggle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hcnt <= '0;
            sclk <= 1'b0;
        end else if (term) begin
            hcnt <= '0;
            sclk <= ~sclk;
        end else begin
            hcnt <= hcnt + 1'b1;
        end
    end
endmodule

// File: rtl/tsf_framer.sv
// Frame sequencer. Counts SCLK periods 0..255 and latches the request for
// the second slot at the fall that ends primary bit 15. Drives the slot
// marker for the period before each active slot. Assumes one-cycle strobes.
module tsf_framer
    import tsf_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rise_en,
    input  logic             fall_en,
    input  logic             req_in,
    output logic [CNT_W-1:0] cnt,
    output logic             sec_active,
    output logic             fsync
);
    // Period index; reset so that the first full period is the marker period.
    always_ff @(posedge clk) begin
        if (!rst_n)       cnt <= 8'd254;
        else if (rise_en) cnt <= cnt + 1'b1;
    end

    // Second-slot request, held from the end of the primary slot to frame end.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sec_active <= 1'b0;
        else if (rise_en && cnt == FRAME_LAST)
            sec_active <= 1'b0;
        else if (fall_en && cnt == SLOT_LAST)
            sec_active <= req_in;
    end

    assign fsync = (cnt == FRAME_LAST) || (cnt == SEC_SYNC && sec_active);
endmodule

// File: rtl/tsf_regfile.sv
// Control register file of 32 addresses by 8 bits. Only the lowest NUM_REGS
// addresses hold storage; the rest read zero and drop writes. Register 1
// bit 0 selects wide mode; register 2 is the clock half-divisor.
module tsf_regfile
    import tsf_pkg::*;
#(
    parameter int NUM_REGS     = 24,
    parameter int DIV_HALF_RST = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata,
    output logic              wide,
    output logic [DATA_W-1:0] half
);
    logic [DATA_W-1:0] mem [NUM_ADDR];

    for (genvar g = 0; g < NUM_ADDR; g++) begin : g_ent
        if (g < NUM_REGS) begin : g_used
            logic [DATA_W-1:0] q;
            // One storage entry with its reset value.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    q <= (g == int'(REG_DIV)) ? DATA_W'(DIV_HALF_RST) : '0;
                else if (we && waddr == ADDR_W'(g))
                    q <= wdata;
            end
            assign mem[g] = q;
        end else begin : g_unused
            assign mem[g] = '0;
        end
    end

    assign rdata = mem[raddr];
    assign wide  = mem[REG_CTRL][0];
    assign half  = mem[REG_DIV];
endmodule

// File: rtl/tsf_port.sv
// Serial frame port top. Shifts the primary slot (rx sample out, tx sample
// in) every frame and the optional second slot (one register access). The
// request source is chosen by the wide bit. Single MCLK domain; SCLK is a
// generated output, not a clock inside the block.
module tsf_port
    import tsf_pkg::*;
#(
    parameter int NUM_REGS     = 24,
    parameter int DIV_HALF_RST = 2
) (
    input  logic                mclk,
    input  logic                rst_n,
    input  logic                sdi,
    input  logic                fc,
    input  logic [SAMPLE_W-1:0] rx_sample,
    output logic                sclk,
    output logic                fsync,
    output logic                sdo,
    output logic [SAMPLE_W-1:0] tx_sample,
    output logic                tx_valid
);
    logic                rise_en, fall_en, sec_active, wide, we, rd_on, req_in;
    logic [CNT_W-1:0]    cnt, nxt, dsel;
    logic [DATA_W-1:0]   half, rdata;
    logic [ADDR_W-1:0]   rd_addr;
    logic [SAMPLE_W-1:0] tx_sh, sec_sh, rx_hold;

    tsf_clkdiv #(.CW(DATA_W)) u_div (
        .clk(mclk), .rst_n(rst_n), .half(half),
        .sclk(sclk), .rise_en(rise_en), .fall_en(fall_en)
    );

    tsf_framer u_frm (
        .clk(mclk), .rst_n(rst_n), .rise_en(rise_en), .fall_en(fall_en),
        .req_in(req_in), .cnt(cnt), .sec_active(sec_active), .fsync(fsync)
    );

    tsf_regfile #(.NUM_REGS(NUM_REGS), .DIV_HALF_RST(DIV_HALF_RST)) u_regs (
        .clk(mclk), .rst_n(rst_n), .we(we), .waddr(sec_sh[12:8]),
        .wdata(sec_sh[7:0]), .raddr(rd_addr), .rdata(rdata),
        .wide(wide), .half(half)
    );

    assign req_in = wide ? fc : sdi;
    assign nxt    = cnt + 1'b1;
    assign dsel   = SEC_DATA_LO - nxt;
    assign we     = fall_en && sec_active && cnt == SEC_LAST && !sec_sh[13];

    // Primary-slot receive shifter and transmit sample hand-off.
    always_ff @(posedge mclk) begin
        if (!rst_n) begin
            tx_sh     <= '0;
            tx_sample <= '0;
            tx_valid  <= 1'b0;
        end else begin
            tx_valid <= 1'b0;
            if (fall_en && cnt <= SLOT_LAST) begin
                tx_sh <= {tx_sh[SAMPLE_W-2:0], sdi};
                if (cnt == SLOT_LAST) begin
                    tx_sample <= wide ? {tx_sh[SAMPLE_W-2:0], sdi}
                                      : {tx_sh[SAMPLE_W-2:0], 1'b0};
                    tx_valid  <= 1'b1;
                end
            end
        end
    end

    // Second-slot shifter and read-address capture after bit 9.
    always_ff @(posedge mclk) begin
        if (!rst_n) begin
            sec_sh  <= '0;
            rd_addr <= '0;
            rd_on   <= 1'b0;
        end else begin
            if (fall_en && sec_active && cnt >= SEC_FIRST && cnt <= SEC_LAST)
                sec_sh <= {sec_sh[SAMPLE_W-2:0], sdi};
            if (rise_en && cnt == FRAME_LAST)
                rd_on <= 1'b0;
            else if (fall_en && sec_active && cnt == SEC_ADDR_DONE) begin
                rd_addr <= {sec_sh[3:0], sdi};
                rd_on   <= sec_sh[4];
            end
        end
    end

    // Serial output: one bit per SCLK rise, zero outside active bits.
    always_ff @(posedge mclk) begin
        if (!rst_n) begin
            sdo     <= 1'b0;
            rx_hold <= '0;
        end else if (rise_en) begin
            if (nxt == '0) begin
                rx_hold <= rx_sample;
                sdo     <= rx_sample[SAMPLE_W-1];
            end else if (nxt <= SLOT_LAST)
                sdo <= rx_hold[~nxt[3:0]];
            else if (rd_on && nxt >= SEC_DATA_HI && nxt <= SEC_DATA_LO)
                sdo <= rdata[dsel[2:0]];
            else
                sdo <= 1'b0;
        end
    end
endmodule

// File: rtl/tsf_port_chk.sv
// Protocol checker for tsf_port, attached by bind. Relates edges of the
// generated bit clock to changes on the serial outputs and the sample strobe.
module tsf_port_chk (
    input logic mclk,
    input logic rst_n,
    input logic sclk,
    input logic fsync,
    input logic sdo,
    input logic tx_valid
);
    assert_sdo_on_rise_R3: assert property (@(posedge mclk) disable iff (!rst_n)
        !$stable(sdo) |-> $rose(sclk));

    assert_fsync_on_rise_R1: assert property (@(posedge mclk) disable iff (!rst_n)
        !$stable(fsync) |-> $rose(sclk));

    assert_sdo_quiet_marker_R6: assert property (@(posedge mclk) disable iff (!rst_n)
        fsync |-> !sdo);

    assert_valid_single_R11: assert property (@(posedge mclk) disable iff (!rst_n)
        tx_valid |=> !tx_valid);

    assert_valid_on_fall_R11: assert property (@(posedge mclk) disable iff (!rst_n)
        $rose(tx_valid) |-> $fell(sclk));
endmodule

bind tsf_port tsf_port_chk u_chk (.*);

// File: tb/tsf_port_bench.sv
// Scoreboard bench: the frame driver acts as host and pushes expected
// transmit samples; a monitor pops them when tx_valid strobes.
module tsf_port_bench;
    logic        mclk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sdi = 1'b0;
    logic        fc = 1'b0;
    logic [15:0] rx_sample = '0;
    logic        sclk, fsync, sdo, tx_valid;
    logic [15:0] tx_sample;

    int          n_chk = 0;
    int          n_bad = 0;
    logic [15:0] exp_q[$];
    logic [7:0]  model [32];
    bit          wide_m = 1'b0;

    tsf_port u_tsf_port (
        .mclk(mclk), .rst_n(rst_n), .sdi(sdi), .fc(fc), .rx_sample(rx_sample),
        .sclk(sclk), .fsync(fsync), .sdo(sdo), .tx_sample(tx_sample),
        .tx_valid(tx_valid)
    );

    always #2.5 mclk = ~mclk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] mkw(input bit rd, input logic [4:0] a, input logic [7:0] d);
        return {1'b0, rd, a, d, 1'b0};
    endfunction

    // Monitor: compare each strobed sample with the scoreboard head.
    always @(negedge mclk) begin
        if (rst_n && tx_valid && exp_q.size() > 0) begin
            logic [15:0] e;
            e = exp_q.pop_front();
            chk("R4 R5 R11 tx_sample", tx_sample, e);
        end
    end

    // Count MCLK cycles in one SCLK period.
    task automatic measure(input int exp_n);
        int n = 0;
        bit low_seen = 0;
        @(posedge sclk);
        #1;
        forever begin
            @(posedge mclk);
            #1;
            n++;
            if (!sclk) low_seen = 1;
            else if (low_seen) break;
        end
        chk("R2 sclk period", n, exp_n);
    endtask

    // One full frame as host, starting in the marker period.
    task automatic do_frame(input logic [15:0] tx, input logic [15:0] rx,
                            input bit fcv, input logic [15:0] sw, input string tag);
        bit          sec;
        logic [15:0] got, got2, exp2;
        logic [4:0]  a;
        while (!fsync) begin
            @(posedge sclk);
            #1;
        end
        sec = wide_m ? fcv : tx[0];
        a = sw[13:9];
        exp2 = (sec && sw[14]) ? {7'b0, (a < 5'd24) ? model[a] : 8'h00, 1'b0} : 16'h0;
        rx_sample = rx;
        fc = fcv;
        exp_q.push_back(wide_m ? tx : {tx[15:1], 1'b0});
        for (int i = 0; i < 16; i++) begin
            @(posedge sclk);
            #1;
            if (i == 0) chk("R1 fsync low in bit 0", fsync, 0);
            sdi = tx[15-i];
            @(negedge sclk);
            #1;
            got[15-i] = sdo;
        end
        chk("R3 primary sdo", got, rx);
        sdi = 1'b0;
        fc = 1'b0;
        for (int p = 16; p < 128; p++) begin
            @(posedge sclk);
            #1;
            if (p == 64) chk("R6 idle sdo", sdo, 0);
            if (p == 127) chk("R6 second-slot marker", fsync, sec);
        end
        for (int i = 0; i < 16; i++) begin
            @(posedge sclk);
            #1;
            sdi = sec ? sw[15-i] : 1'b0;
            @(negedge sclk);
            #1;
            got2[15-i] = sdo;
        end
        chk(tag, got2, exp2);
        sdi = 1'b0;
        for (int p = 144; p < 256; p++) begin
            @(posedge sclk);
            #1;
        end
        chk("R1 frame marker at period 255", fsync, 1);
        if (sec && !sw[14] && a < 5'd24) begin
            model[a] = sw[8:1];
            if (a == 5'd1) wide_m = sw[1];
        end
    endtask

    initial begin
        repeat (200000) @(posedge mclk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk + 1 - n_bad, n_chk + 1);
        $finish;
    end

    initial begin
        for (int i = 0; i < 32; i++) model[i] = 8'h00;
        model[2] = 8'h02;
        repeat (10) @(posedge mclk);
        @(negedge mclk);
        rst_n = 1'b1;
        #1;
        chk("R10 sdo", sdo, 0);
        chk("R10 tx_valid", tx_valid, 0);
        chk("R10 fsync", fsync, 0);
        chk("R10 sclk", sclk, 0);
        measure(4);
        do_frame(16'hA5A4, 16'h1234, 0, mkw(1, 5'd5, 8'h00), "R6 no second slot");
        do_frame(16'h3C01, 16'hBEEF, 0, mkw(0, 5'd5, 8'hC3), "R7 write slot sdo");
        do_frame(16'h7FFF, 16'h8001, 0, mkw(1, 5'd5, 8'h00), "R7 R8 read back");
        do_frame(16'h0001, 16'h5A5A, 0, mkw(0, 5'd27, 8'h55), "R9 unused write");
        do_frame(16'h0003, 16'h0F0F, 0, mkw(1, 5'd27, 8'h00), "R9 unused read");
        do_frame(16'h1111, 16'hF00D, 0, mkw(1, 5'd2, 8'h00), "R10 divisor reset value");
        do_frame(16'hFFFE, 16'h0000, 1, mkw(1, 5'd5, 8'h00), "R4 fc ignored");
        do_frame(16'h0001, 16'hFFFF, 0, mkw(0, 5'd1, 8'h01), "R7 set wide");
        do_frame(16'h8001, 16'hC001, 0, mkw(1, 5'd5, 8'h00), "R5 no request");
        do_frame(16'h4242, 16'h2468, 1, mkw(1, 5'd1, 8'h00), "R5 R8 fc read");
        do_frame(16'h0000, 16'h1357, 1, mkw(0, 5'd2, 8'h03), "R2 write divisor");
        measure(6);
        do_frame(16'h9999, 16'h7531, 1, mkw(0, 5'd2, 8'h00), "R2 write zero");
        measure(2);
        do_frame(16'h6666, 16'hABCD, 1, mkw(1, 5'd5, 8'h00), "R2 R8 fast read");
        repeat (20) @(posedge mclk);
        chk("R11 scoreboard drained", exp_q.size(), 0);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule